// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the register file through which software manages a small translation table. It holds an entry-select register, a process identifier, a zone-protection word, and two windows onto the entry that the select register points at: a tag word and a 64-bit data word. The data word is reached as two 32-bit halves, chosen by an upper-half flag. A write-only search register takes an address and scans the table for an entry that would translate it as a read in the current mode. The result goes back into the select register as a matching index or as a miss flag.

Several accesses change more than the register they name. A tag write stamps the entry with the low byte of the current process identifier. A tag read copies the entry's stamp back into the process identifier. A search rewrites the select register. Every access is gated by a 2-bit access level.

The controller has two states. `ST_IDLE` accepts register accesses. `ST_SCAN` checks one entry per cycle. The transition *start search* (`ST_IDLE`→`ST_SCAN`) fires on a permitted search write. The transition *scan done* (`ST_SCAN`→`ST_IDLE`) fires on the first matching entry or after the last entry. `busy` is high in `ST_SCAN`.

Register codes on `reg_sel`: 0 data window, 1 tag window, 2 zone protection, 3 process ID, 4 entry select, 5 search. Codes 6 and 7 are unused.

Top module: `tlbm_regif`

## Requirements
- R1: After reset the entry select, process ID and zone registers read 0, every table entry is invalid, `rdata` is 0 and `busy` is low.
- R2: A write to entry select updates only bits [30:0]. Bit 31 (the miss flag) keeps its value. The low log2(NUM_ENTRIES) bits choose the entry seen through the tag and data windows.
- R3: A tag-window write stores the word in the selected entry and copies process ID bits [7:0] into that entry's translation ID.
- R4: A tag-window read returns the stored tag word and loads the entry's translation ID, zero-extended, into the process ID register.
- R5: The data window reads and writes the lower half of the entry's data word when `acc_ext`=0 and the upper half when `acc_ext`=1.
- R6: A search write clears bits [9:0] of the written value and checks entries 0 to NUM_ENTRIES-1, one per cycle, while `busy` is high. The lowest-indexed hit writes its index, zero-extended, into entry select, which also clears bit 31. A full miss sets bit 31 and leaves bits [30:0] unchanged.
- R7: An entry matches when tag bit 6 (valid) is set, its translation ID is 0 or equals process ID[7:0], and the address agrees with tag bits [31:10] above the page offset. The page size is 1 KiB × 4^f, where f is tag bits [9:7].
- R8: Data bits [7:4] select a zone z, whose 2-bit field is zone register bits [31-2z:30-2z]. In user mode (`user_mode`=1) an entry whose zone field is 00 is skipped by the search.
- R9: Reading the search register returns 0.
- R10: With `acc_ext`=1, any register other than the data window reads 0 and ignores writes.
- R11: At access level 0 every access reads 0 and writes nothing. Writes to process ID, zone and search need level 2 or 3. Reads of the data, tag, process ID and zone registers need level bit 0. Entry-select reads and writes, and data and tag writes, need any nonzero level.
- R12: Register codes 6 and 7 read 0 and ignore writes.
- R13: Accesses presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_lvl | input | 2 | Access level for register accesses |
| user_mode | input | 1 | Search runs as a user-mode read when 1 |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Register code |
| acc_ext | input | 1 | Upper-half access flag |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| busy | output | 1 | Search in progress |

## Verification
A read's data appears on `rdata` one cycle after the accepting edge. A write's effect is visible to any access issued on the next cycle. A search result lands in entry select at most NUM_ENTRIES edges after the search write, and `busy` falls in the same cycle. Each bench access drives its inputs on a falling edge and releases them one cycle later. It then waits on falling edges until `busy` is low before it samples `rdata` or issues the read that checks a search result. No check depends on a fixed search latency.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam logic [2:0] RG_DATA   = 3'd0;
    localparam logic [2:0] RG_TAG    = 3'd1;
    localparam logic [2:0] RG_ZONE   = 3'd2;
    localparam logic [2:0] RG_PID    = 3'd3;
    localparam logic [2:0] RG_INDEX  = 3'd4;
    localparam logic [2:0] RG_SEARCH = 3'd5;

    localparam int TAG_VALID_BIT = 6;
    localparam int TID_W         = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } tlbm_state_e;
endpackage

// File: rtl/tlbm_entry_store.sv
module tlbm_entry_store #(
    parameter int NUM_ENTRIES = 8,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             we_tag,
    input  logic [31:0]      tag_wdata,
    input  logic [7:0]       tid_wdata,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [31:0]      data_wdata,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [31:0]      tag_a,
    output logic [63:0]      data_a,
    output logic [7:0]       tid_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [31:6]      tag_b,
    output logic [7:4]       zone_b,
    output logic [7:0]       tid_b
);
    logic [31:0] tag_r  [NUM_ENTRIES];
    logic [63:0] data_r [NUM_ENTRIES];
    logic [7:0]  tid_r  [NUM_ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                tag_r[e]  <= '0;
                data_r[e] <= '0;
                tid_r[e]  <= '0;
            end
        end else begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (wr_idx == IDX_W'(e)) begin
                    if (we_tag) begin
                        tag_r[e] <= tag_wdata;
                        tid_r[e] <= tid_wdata;
                    end
                    if (we_lo) data_r[e][31:0]  <= data_wdata;
                    if (we_hi) data_r[e][63:32] <= data_wdata;
                end
            end
        end
    end

    assign tag_a  = tag_r[rd_idx_a];
    assign data_a = data_r[rd_idx_a];
    assign tid_a  = tid_r[rd_idx_a];

    always_comb begin
        logic [31:0] t;
        logic [63:0] d;
        t      = tag_r[rd_idx_b];
        d      = data_r[rd_idx_b];
        tag_b  = t[31:6];
        zone_b = d[7:4];
        tid_b  = tid_r[rd_idx_b];
    end
endmodule

// File: rtl/tlbm_match.sv
module tlbm_match (
    input  logic [31:6]  tag_hi,
    input  logic [7:4]   zone_sel,
    input  logic [7:0]   tid,
    input  logic [7:0]   pid8,
    input  logic [31:0]  zpr,
    input  logic         user_mode,
    input  logic [31:10] page,
    output logic         hit
);
    logic        valid;
    logic [2:0]  size_f;
    logic [21:0] cmp_mask;
    logic        addr_ok;
    logic        tid_ok;
    logic [4:0]  zshift;
    logic [1:0]  zfield;
    logic        zone_deny;

    always_comb begin
        valid     = tag_hi[tlbm_pkg::TAG_VALID_BIT];
        size_f    = tag_hi[9:7];
        cmp_mask  = 22'h3F_FFFF << {size_f, 1'b0};
        addr_ok   = ((page ^ tag_hi[31:10]) & cmp_mask) == '0;
        tid_ok    = (tid == 8'd0) || (tid == pid8);
        zshift    = 5'd30 - {zone_sel, 1'b0};
        zfield    = 2'((zpr >> zshift) & 32'd3);
        zone_deny = user_mode && (zfield == 2'b00);
        hit       = valid && addr_ok && tid_ok && !zone_deny;
    end
endmodule

// File: rtl/tlbm_regif.sv
module tlbm_regif #(
    parameter int NUM_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  acc_lvl,
    input  logic        user_mode,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [2:0]  reg_sel,
    input  logic        acc_ext,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        busy
);
    import tlbm_pkg::*;

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    tlbm_state_e state_q, state_d;

    logic [31:0]     pid_q, zpr_q, index_q, rdata_q;
    logic [IDX_W-1:0] scan_q;
    logic [31:10]    page_q;
    logic            umode_q;

    logic            idle, go, wr_ok, rd_ok, do_wr, do_rd, rd_req;
    logic            we_tag, we_lo, we_hi, last;
    logic [31:0]     tag_a, rd_val;
    logic [63:0]     data_a;
    logic [7:0]      tid_a, tid_b;
    logic [31:6]     tag_b;
    logic [7:4]      zone_b;
    logic            hit;
    logic [IDX_W-1:0] sel_idx;

    // Access decode and level gating
    always_comb begin
        idle = (state_q == ST_IDLE);
        go   = acc_en && idle && (acc_lvl != 2'b00) && (!acc_ext || reg_sel == RG_DATA);
        unique case (reg_sel)
            RG_DATA, RG_TAG, RG_INDEX:  wr_ok = 1'b1;
            RG_PID, RG_ZONE, RG_SEARCH: wr_ok = acc_lvl[1];
            default:                    wr_ok = 1'b0;
        endcase
        unique case (reg_sel)
            RG_DATA, RG_TAG, RG_PID, RG_ZONE: rd_ok = acc_lvl[0];
            RG_INDEX:                         rd_ok = 1'b1;
            default:                          rd_ok = 1'b0;
        endcase
        do_wr   = go && acc_wr && wr_ok;
        do_rd   = go && !acc_wr && rd_ok;
        rd_req  = acc_en && !acc_wr && idle;
        we_tag  = do_wr && (reg_sel == RG_TAG);
        we_lo   = do_wr && (reg_sel == RG_DATA) && !acc_ext;
        we_hi   = do_wr && (reg_sel == RG_DATA) && acc_ext;
        sel_idx = index_q[IDX_W-1:0];
        last    = (scan_q == LAST_IDX);
    end

    always_comb begin
        unique case (reg_sel)
            RG_DATA:  rd_val = acc_ext ? data_a[63:32] : data_a[31:0];
            RG_TAG:   rd_val = tag_a;
            RG_ZONE:  rd_val = zpr_q;
            RG_PID:   rd_val = pid_q;
            RG_INDEX: rd_val = index_q;
            default:  rd_val = '0;
        endcase
    end

    tlbm_entry_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_idx     (sel_idx),
        .we_tag     (we_tag),
        .tag_wdata  (wdata),
        .tid_wdata  (pid_q[7:0]),
        .we_lo      (we_lo),
        .we_hi      (we_hi),
        .data_wdata (wdata),
        .rd_idx_a   (sel_idx),
        .tag_a      (tag_a),
        .data_a     (data_a),
        .tid_a      (tid_a),
        .rd_idx_b   (scan_q),
        .tag_b      (tag_b),
        .zone_b     (zone_b),
        .tid_b      (tid_b)
    );

    tlbm_match u_match (
        .tag_hi    (tag_b),
        .zone_sel  (zone_b),
        .tid       (tid_b),
        .pid8      (pid_q[7:0]),
        .zpr       (zpr_q),
        .user_mode (umode_q),
        .page      (page_q),
        .hit       (hit)
    );

    // Next state: start search / scan done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (do_wr && reg_sel == RG_SEARCH) state_d = ST_SCAN;
            ST_SCAN: if (hit || last)                   state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Register file and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q   <= '0;
            zpr_q   <= '0;
            index_q <= '0;
            rdata_q <= '0;
            scan_q  <= '0;
            page_q  <= '0;
            umode_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (do_wr) begin
                        unique case (reg_sel)
                            RG_PID:   pid_q <= wdata;
                            RG_ZONE:  zpr_q <= wdata;
                            RG_INDEX: index_q[30:0] <= wdata[30:0];
                            RG_SEARCH: begin
                                page_q  <= wdata[31:10];
                                umode_q <= user_mode;
                                scan_q  <= '0;
                            end
                            default: ;
                        endcase
                    end
                    if (rd_req) begin
                        rdata_q <= do_rd ? rd_val : 32'd0;
                        if (do_rd && reg_sel == RG_TAG) pid_q <= {24'd0, tid_a};
                    end
                end
                ST_SCAN: begin
                    if (hit)       index_q    <= 32'(scan_q);
                    else if (last) index_q[31] <= 1'b1;
                    scan_q <= scan_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign rdata = rdata_q;
    assign busy  = (state_q == ST_SCAN);

    AST_MISS_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && reg_sel == RG_INDEX) |=> index_q[31] == $past(index_q[31])); // R2
    AST_TID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        we_tag |=> tid_a == $past(pid_q[7:0])); // R3
    AST_PID_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && reg_sel == RG_TAG) |=> pid_q == {24'd0, $past(tid_a)}); // R4
    AST_MISS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !hit && last) |=> (index_q[31] && !busy)); // R6
    AST_SEARCH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && reg_sel == RG_SEARCH) |=> rdata == 32'd0); // R9
    AST_NO_LEVEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && acc_lvl == 2'b00) |=> rdata == 32'd0); // R11
    AST_NO_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && idle && acc_lvl == 2'b00)
        |=> ($stable(pid_q) && $stable(zpr_q) && $stable(index_q))); // R11
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_en && acc_wr && reg_sel == RG_PID) |=> $stable(pid_q)); // R13
endmodule

// File: tb/tlbm_regif_bench.sv
module tlbm_regif_bench;
    localparam logic [2:0] D = 3'd0, T = 3'd1, Z = 3'd2, P = 3'd3, X = 3'd4, S = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_lvl = 2'd3;
    logic        user_mode = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic        acc_ext = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tlbm_regif u_tlbm_regif (
        .clk(clk), .rst_n(rst_n), .acc_lvl(acc_lvl), .user_mode(user_mode),
        .acc_en(acc_en), .acc_wr(acc_wr), .reg_sel(reg_sel), .acc_ext(acc_ext),
        .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // fields: [74:71] req, [70] wr, [69:67] reg, [66] ext, [65:64] lvl, [63:32] wdata, [31:0] expected
    function automatic logic [74:0] vec(int r, bit w, logic [2:0] rg, bit e, logic [1:0] lv,
                                        logic [31:0] wd, logic [31:0] ex);
        return {4'(r), w, rg, e, lv, wd, ex};
    endfunction

    localparam int NV = 38;
    localparam logic [74:0] VEC [NV] = '{
        vec(3, 1, P, 0, 3, 32'h25, 0),                // R3 set PID
        vec(2, 1, X, 0, 3, 32'h2, 0),                 // R2 select entry 2
        vec(3, 1, T, 0, 3, 32'h0001_2040, 0),         // R3 tag write stamps 0x25
        vec(5, 1, D, 0, 3, 32'hABCD_0000, 0),         // R5 lower half
        vec(5, 1, D, 1, 3, 32'h1234_5678, 0),         // R5 upper half
        vec(5, 0, D, 0, 3, 0, 32'hABCD_0000),         // R5
        vec(5, 0, D, 1, 3, 0, 32'h1234_5678),         // R5
        vec(11, 1, P, 0, 3, 32'h7, 0),                // R11
        vec(11, 0, P, 0, 3, 0, 32'h7),                // R11
        vec(4, 0, T, 0, 3, 0, 32'h0001_2040),         // R4 tag read
        vec(4, 0, P, 0, 3, 0, 32'h25),                // R4 PID restored
        vec(2, 1, X, 0, 3, 32'h5, 0),                 // R2
        vec(6, 1, S, 0, 3, 32'h0001_23FF, 0),         // R6 hit entry 2
        vec(6, 0, X, 0, 3, 0, 32'h2),                 // R6
        vec(6, 1, S, 0, 3, 32'h0009_9000, 0),         // R6 miss
        vec(6, 0, X, 0, 3, 0, 32'h8000_0002),         // R6
        vec(2, 1, X, 0, 3, 32'hFFFF_FFF1, 0),         // R2
        vec(2, 0, X, 0, 3, 0, 32'hFFFF_FFF1),         // R2
        vec(2, 1, X, 0, 3, 32'h2, 0),                 // R2 bit 31 kept
        vec(2, 0, X, 0, 3, 0, 32'h8000_0002),         // R2
        vec(9, 0, S, 0, 3, 0, 0),                     // R9
        vec(10, 0, T, 1, 3, 0, 0),                    // R10
        vec(10, 1, P, 1, 3, 32'h55, 0),               // R10
        vec(10, 0, P, 0, 3, 0, 32'h25),               // R10
        vec(11, 1, P, 0, 1, 32'h66, 0),               // R11
        vec(11, 0, P, 0, 1, 0, 32'h25),               // R11
        vec(11, 1, Z, 0, 1, 32'h1, 0),                // R11
        vec(11, 0, Z, 0, 3, 0, 0),                    // R11
        vec(11, 0, P, 0, 2, 0, 0),                    // R11
        vec(11, 0, X, 0, 2, 0, 32'h8000_0002),        // R11
        vec(11, 1, X, 0, 0, 32'h0, 0),                // R11
        vec(11, 0, X, 0, 0, 0, 0),                    // R11
        vec(11, 0, X, 0, 3, 0, 32'h8000_0002),        // R11
        vec(12, 1, 3'd7, 0, 3, 32'h123, 0),           // R12
        vec(12, 0, 3'd7, 0, 3, 0, 0),                 // R12
        vec(12, 0, 3'd6, 0, 3, 0, 0),                 // R12
        vec(8, 1, Z, 0, 3, 32'h4000_0000, 0),         // R8
        vec(8, 0, Z, 0, 3, 0, 32'h4000_0000)          // R8
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(bit w, logic [2:0] rg, bit e, logic [1:0] lv, logic [31:0] wd);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = w; reg_sel = rg; acc_ext = e; acc_lvl = lv; wdata = wd;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; acc_ext = 1'b0; wdata = '0;
        while (busy) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] rg, logic [31:0] wd);
        access(1'b1, rg, 1'b0, 2'd3, wd);
    endtask

    task automatic rd_chk(string req, logic [2:0] rg, logic [31:0] exp);
        access(1'b0, rg, 1'b0, 2'd3, 32'd0);
        check(req, rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 rdata", rdata, 0);
        rd_chk("R1 index", X, 0);
        rd_chk("R1 pid", P, 0);
        rd_chk("R1 zone", Z, 0);
        rd_chk("R1 tag", T, 0);

        for (int i = 0; i < NV; i++) begin
            logic [74:0] v;
            v = VEC[i];
            access(v[70], v[69:67], v[66], v[65:64], v[63:32]);
            if (!v[70]) begin
                n_checks++;
                if (rdata !== v[31:0]) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d actual=%h expected=%h", v[74:71], i, rdata, v[31:0]);
                end
            end
        end

        // R8 zone field 00 blocks user-mode search
        wr(Z, 32'h0);
        wr(S, 32'h0001_2000);
        rd_chk("R8 supervisor hit", X, 32'h2);
        user_mode = 1'b1;
        wr(S, 32'h0001_2000);
        rd_chk("R8 user blocked", X, 32'h8000_0002);
        wr(Z, 32'h4000_0000);
        wr(S, 32'h0001_2000);
        rd_chk("R8 user allowed", X, 32'h2);
        user_mode = 1'b0;

        // R7 translation ID mismatch
        wr(P, 32'h30);
        wr(S, 32'h0001_2000);
        rd_chk("R7 tid mismatch", X, 32'h8000_0002);

        // R6 lowest hit wins; global entries with ID 0
        wr(P, 32'h0);
        wr(X, 32'h5); wr(T, 32'h0001_2040);
        wr(X, 32'h6); wr(T, 32'h0001_2040);
        wr(P, 32'h30);
        wr(S, 32'h0001_2000);
        rd_chk("R6 priority global", X, 32'h5);
        wr(P, 32'h25);
        wr(S, 32'h0001_2000);
        rd_chk("R6 priority lowest", X, 32'h2);

        // R7 page size f=2 (16 KiB)
        wr(P, 32'h0);
        wr(X, 32'h7); wr(T, 32'h0040_0140);
        wr(S, 32'h0040_3000);
        rd_chk("R7 large page hit", X, 32'h7);
        wr(S, 32'h0040_4000);
        rd_chk("R7 large page miss", X, 32'h8000_0007);

        // R7 invalid entry never matches
        wr(X, 32'h3); wr(T, 32'h0050_0000);
        wr(S, 32'h0050_0000);
        rd_chk("R7 invalid entry", X, 32'h8000_0003);

        // R13 write during scan ignored
        wr(P, 32'h11);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; reg_sel = S; acc_lvl = 2'd3; wdata = 32'h0009_9000;
        @(negedge clk);
        check("R13 busy during scan", {31'd0, busy}, 1);
        reg_sel = P; wdata = 32'h77;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0; wdata = '0;
        while (busy) @(negedge clk);
        rd_chk("R13 pid untouched", P, 32'h11);

        // R1 second reset clears table
        do_reset();
        rd_chk("R1 pid after reset", P, 0);
        wr(S, 32'h0001_2000);
        rd_chk("R1 entries invalid", X, 32'h8000_0000);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule